// File: doc/BRIEF.md
# Keyed SDRAM Command Port

A host-side register block that lets software push one SDRAM command at a time around the normal memory path. Software loads a target address register, optionally a payload register, then writes a command word. The upper 16 bits of that word must carry the unlock key 0xA55A and the low nibble carries the command code. When the key, the code and the address are all good, the block offers a request to a downstream SDRAM command engine over a valid/ready handshake. It then waits for that engine's response pulse.

The response sets one of two sticky status flags: done or error. A read that completes without error leaves its data word in a receive register. Software polls the status register until one flag sets and clears flags by writing ones to them. Bad command writes never reach the downstream engine and only raise the error flag. A command word is bad if it has the wrong key, a reserved or undefined code, no fresh address, or arrives while an earlier command is still outstanding.

Register map (index on `reg_sel`): 0 target address, 1 payload, 2 command word, 3 status (bit 0 done, bit 1 error, write-one-to-clear), 4 receive data.

Top module: `sdcmd_port`

## Requirements
- R1: After reset, status reads 0, receive data reads 0 and `req_valid` is low.
- R2: A command-register write whose bits [31:16] are 0xA55A and whose code in bits [3:0] is 0x8..0xF, with an address written since the previous command write and no command outstanding, raises `req_valid` from the next cycle. The request carries that code on `req_code` and the address register value on `req_addr`.
- R3: `req_data` carries the payload register for code 0x9 (write) and code 0xA (mode-register set), and zero for every other code.
- R4: A command write whose bits [31:16] differ from 0xA55A issues no request and sets the error flag (status bit 1).
- R5: A command write with code 0x0 or 0x1 (reserved for bus-master traffic), or with an undefined code 0x2..0x7, issues no request and sets the error flag.
- R6: Every command-register write consumes the address register's armed state. A command written with no address write since the previous command write issues no request and sets the error flag.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_code`, `req_addr` and `req_data` hold their values.
- R8: A response pulse with `rsp_err` low sets the done flag (status bit 0). One with `rsp_err` high sets the error flag. Both flags stay set until cleared.
- R9: A response without error to a read (code 0x8) loads `rsp_rdata` into the receive register. Other responses leave that register unchanged.
- R10: Writing the status register clears each flag whose bit is 1 in the written data. Bits written as 0 leave their flag unchanged.
- R11: A command write while a command is outstanding sets the error flag and leaves the outstanding request and its fields untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Host register index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_sel` (combinational) |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request accepted |
| req_code | output | 4 | Command code of the request |
| req_addr | output | ADDR_W | Target address of the request |
| req_data | output | DATA_W | Payload of the request |
| rsp_valid | input | 1 | One-cycle response pulse |
| rsp_err | input | 1 | Response reports a failed command |
| rsp_rdata | input | DATA_W | Read data returned with the response |

## Verification
A command written at one clock edge shows on `req_valid` and the request fields right after that edge. A rejection likewise shows as the error bit on the status register right after that edge. A response pulse updates the flags and the receive register at the edge where it is sampled. The bench drives every input at a falling edge and reads results at the following falling edge, half a period after the edge that produced them. Flag clears and the busy-time rejection are checked the same way, one edge after the write that causes them.

// File: rtl/sdcmd_pkg.sv
// Shared definitions for the keyed SDRAM command port: key value,
// command codes, register indices, status bit positions, engine states.
package sdcmd_pkg;

    localparam int          REG_W    = 32;
    localparam int          SEL_W    = 3;
    localparam logic [15:0] CMD_KEY  = 16'hA55A;

    localparam logic [SEL_W-1:0] SEL_ADDR = 3'd0;
    localparam logic [SEL_W-1:0] SEL_TXD  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_CMD  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd3;
    localparam logic [SEL_W-1:0] SEL_RXD  = 3'd4;

    localparam int BIT_DONE = 0;
    localparam int BIT_ERR  = 1;

    typedef enum logic [3:0] {
        OP_BUS_RD = 4'h0,
        OP_BUS_WR = 4'h1,
        OP_READ   = 4'h8,
        OP_WRITE  = 4'h9,
        OP_MODE   = 4'hA,
        OP_ACT    = 4'hB,
        OP_AREF   = 4'hC,
        OP_SREF   = 4'hD,
        OP_PRE    = 4'hE,
        OP_PREALL = 4'hF
    } op_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ISSUE = 2'd1,
        ENG_WAIT  = 2'd2
    } eng_state_e;

endpackage

// File: rtl/sdcmd_decode.sv
// Command word decoder.
// Does: checks the unlock key in the upper half, classifies the low-nibble
// code as issuable or not, and flags codes that carry a payload.
// Assumes: purely combinational; the caller qualifies outputs with a write.
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic [REG_W-1:0] cmd_word,
    output logic             key_ok,
    output logic             code_ok,
    output logic [3:0]       code,
    output logic             uses_payload
);

    // Key compare and code extraction.
    always_comb begin
        key_ok = (cmd_word[REG_W-1:REG_W-16] == CMD_KEY);
        code   = cmd_word[3:0];
    end

    // Code classification: only the memory-command codes may go out.
    always_comb begin
        code_ok      = 1'b0;
        uses_payload = 1'b0;
        case (op_e'(cmd_word[3:0]))
            OP_READ, OP_ACT, OP_AREF, OP_SREF, OP_PRE, OP_PREALL: code_ok = 1'b1;
            OP_WRITE, OP_MODE: begin
                code_ok      = 1'b1;
                uses_payload = 1'b1;
            end
            default: code_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdcmd_regs.sv
// Host data registers: target address, payload, receive data, armed flag.
// Does: loads address and payload on host writes, arms on an address write,
// disarms on any command write, captures read data when told to.
// Assumes: at most one host write per cycle; synchronous active-low reset.
module sdcmd_regs #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              txd_we,
    input  logic              cmd_we,
    input  logic [31:0]       wdata,
    input  logic              rx_cap,
    input  logic [DATA_W-1:0] rx_cap_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] txd_q,
    output logic [DATA_W-1:0] rxd_q,
    output logic              armed_q
);

    // Target address and payload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            txd_q  <= '0;
        end else begin
            if (addr_we) addr_q <= wdata[ADDR_W-1:0];
            if (txd_we)  txd_q  <= wdata[DATA_W-1:0];
        end
    end

    // Armed flag: a fresh address is good for exactly one command write.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (addr_we) armed_q <= 1'b1;
        else if (cmd_we)  armed_q <= 1'b0;
    end

    // Receive data register, loaded on a successful read completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      rxd_q <= '0;
        else if (rx_cap) rxd_q <= rx_cap_data;
    end

    // R9
    rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cap |=> rxd_q == $past(rx_cap_data));

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_cap |=> $stable(rxd_q));

    // R6
    cmd_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !addr_we) |=> !armed_q);

endmodule

// File: rtl/sdcmd_engine.sv
// Command sequencer and status flags.
// Does: accepts a checked command, offers it downstream until taken, waits
// for the response, and keeps the sticky done and error flags.
// Assumes: one command outstanding at most; the response arrives only
// after the request was taken; synchronous active-low reset.
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              key_ok,
    input  logic              code_ok,
    input  logic              armed,
    input  logic [3:0]        code,
    input  logic              uses_payload,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] txd,
    input  logic              stat_we,
    input  logic [1:0]        stat_clr,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [3:0]        req_code,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              done_q,
    output logic              err_q,
    output logic              rx_cap,
    output logic [DATA_W-1:0] rx_cap_data
);

    eng_state_e state_q;
    logic       busy;
    logic       accept;
    logic       reject;
    logic       rsp_take;
    logic       set_done;
    logic       set_err;

    // Accept/reject and response qualification.
    always_comb begin
        busy     = (state_q != ENG_IDLE);
        accept   = cmd_we && !busy && key_ok && code_ok && armed;
        reject   = cmd_we && !accept;
        rsp_take = (state_q == ENG_WAIT) && rsp_valid;
        set_done = rsp_take && !rsp_err;
        set_err  = reject || (rsp_take && rsp_err);
        rx_cap   = set_done && (req_code == OP_READ);
        rx_cap_data = rsp_rdata;
        req_valid   = (state_q == ENG_ISSUE);
    end

    // Sequencer: idle -> offer request -> await response -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
        end else begin
            case (state_q)
                ENG_IDLE:  if (accept)    state_q <= ENG_ISSUE;
                ENG_ISSUE: if (req_ready) state_q <= ENG_WAIT;
                ENG_WAIT:  if (rsp_valid) state_q <= ENG_IDLE;
                default:                  state_q <= ENG_IDLE;
            endcase
        end
    end

    // Request fields latched at acceptance and held until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_code <= '0;
            req_addr <= '0;
            req_data <= '0;
        end else if (accept) begin
            req_code <= code;
            req_addr <= addr;
            req_data <= uses_payload ? txd : '0;
        end
    end

    // Sticky flags: a set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (set_done)                        done_q <= 1'b1;
            else if (stat_we && stat_clr[BIT_DONE]) done_q <= 1'b0;
            if (set_err)                         err_q  <= 1'b1;
            else if (stat_we && stat_clr[BIT_ERR])  err_q  <= 1'b0;
        end
    end

    // R2
    accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && key_ok && code_ok && armed)
        |=> req_valid && req_code == $past(code) && req_addr == $past(addr));

    // R4
    bad_cmd_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && !(key_ok && code_ok && armed)) |=> !req_valid && err_q);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready)
        |=> req_valid && $stable(req_code) && $stable(req_addr) && $stable(req_data));

    // R8
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_WAIT && rsp_valid && !rsp_err) |=> done_q);

    // R11
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && busy) |=> err_q && $stable(req_code) && $stable(req_addr));

    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && stat_clr[BIT_DONE] && !(state_q == ENG_WAIT && rsp_valid)) |=> !done_q);

endmodule

// File: rtl/sdcmd_port.sv
// Keyed SDRAM command port, top level.
// Does: decodes host register writes, routes them to the data registers,
// the key/code decoder and the sequencer, and muxes host reads.
// Assumes: ADDR_W and DATA_W are at most 32; reads are combinational.
module sdcmd_port
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [3:0]        req_code,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [DATA_W-1:0] rsp_rdata
);

    logic              addr_we, txd_we, cmd_we, stat_we;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] txd_q, rxd_q, rx_cap_data;
    logic              armed_q, rx_cap;
    logic              key_ok, code_ok, uses_payload;
    logic [3:0]        code;
    logic              done_q, err_q;

    // Host write strobes per register index.
    always_comb begin
        addr_we = reg_we && (reg_sel == SEL_ADDR);
        txd_we  = reg_we && (reg_sel == SEL_TXD);
        cmd_we  = reg_we && (reg_sel == SEL_CMD);
        stat_we = reg_we && (reg_sel == SEL_STAT);
    end

    sdcmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_we     (addr_we),
        .txd_we      (txd_we),
        .cmd_we      (cmd_we),
        .wdata       (reg_wdata),
        .rx_cap      (rx_cap),
        .rx_cap_data (rx_cap_data),
        .addr_q      (addr_q),
        .txd_q       (txd_q),
        .rxd_q       (rxd_q),
        .armed_q     (armed_q)
    );

    sdcmd_decode u_decode (
        .cmd_word     (reg_wdata),
        .key_ok       (key_ok),
        .code_ok      (code_ok),
        .code         (code),
        .uses_payload (uses_payload)
    );

    sdcmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (cmd_we),
        .key_ok       (key_ok),
        .code_ok      (code_ok),
        .armed        (armed_q),
        .code         (code),
        .uses_payload (uses_payload),
        .addr         (addr_q),
        .txd          (txd_q),
        .stat_we      (stat_we),
        .stat_clr     (reg_wdata[1:0]),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_code     (req_code),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .rsp_valid    (rsp_valid),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata),
        .done_q       (done_q),
        .err_q        (err_q),
        .rx_cap       (rx_cap),
        .rx_cap_data  (rx_cap_data)
    );

    // Host read mux; the command word reads back as zero.
    always_comb begin
        case (reg_sel)
            SEL_ADDR: reg_rdata = 32'(addr_q);
            SEL_TXD:  reg_rdata = 32'(txd_q);
            SEL_STAT: reg_rdata = {30'd0, err_q, done_q};
            SEL_RXD:  reg_rdata = 32'(rxd_q);
            default:  reg_rdata = '0;
        endcase
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !req_valid && !done_q && !err_q);

endmodule

// File: tb/test_sdcmd_port.sv
`timescale 1ns/1ps
module test_sdcmd_port;

    localparam time CLK_HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [3:0]  req_code;
    logic [31:0] req_addr;
    logic [31:0] req_data;
    logic        rsp_valid = 1'b0;
    logic        rsp_err = 1'b0;
    logic [31:0] rsp_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #CLK_HALF clk = ~clk;

    sdcmd_port i_sdcmd_port (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_code(req_code),
        .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic        do_addr;
        logic [31:0] addr;
        logic [31:0] txd;
        logic [31:0] cmd;
        logic        rerr;
        logic [31:0] rdat;
        logic        exp_req;
        logic [31:0] exp_data;
        logic [1:0]  exp_st;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h0000_1000, 32'h0000_0011, 32'hA55A_000F, 1'b0, 32'h0, 1'b1, 32'h0,         2'b01}, // R2 R3 precharge all
        '{1'b1, 32'h0000_1004, 32'hDEAD_BEEF, 32'hA55A_0009, 1'b0, 32'h0, 1'b1, 32'hDEAD_BEEF, 2'b01}, // R3 write
        '{1'b1, 32'h0000_2000, 32'h0000_0032, 32'hA55A_000A, 1'b0, 32'h0, 1'b1, 32'h0000_0032, 2'b01}, // R3 mode set
        '{1'b1, 32'h0000_3008, 32'h5555_5555, 32'hA55A_0008, 1'b0, 32'hCAFE_0123, 1'b1, 32'h0, 2'b01}, // R9 read
        '{1'b1, 32'h0000_0000, 32'h0,         32'hA55A_000C, 1'b1, 32'h1111_2222, 1'b1, 32'h0, 2'b10}, // R8 error response
        '{1'b1, 32'h0000_4000, 32'h0,         32'h5AA5_000B, 1'b0, 32'h0, 1'b0, 32'h0,         2'b10}, // R4 bad key
        '{1'b1, 32'h0000_4000, 32'h0,         32'hA55A_0001, 1'b0, 32'h0, 1'b0, 32'h0,         2'b10}, // R5 reserved
        '{1'b1, 32'h0000_4000, 32'h0,         32'hA55A_0005, 1'b0, 32'h0, 1'b0, 32'h0,         2'b10}, // R5 undefined
        '{1'b0, 32'h0000_4000, 32'h0,         32'hA55A_000B, 1'b0, 32'h0, 1'b0, 32'h0,         2'b10}  // R6 no address
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic take_and_respond(input logic e, input logic [31:0] dat);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        rsp_valid = 1'b1; rsp_err = e; rsp_rdata = dat;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd3, v); check("R1 status", v, 32'h0);
        rd(3'd4, v); check("R1 rxdata", v, 32'h0);
        check("R1 req_valid", {31'd0, req_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].do_addr) wr(3'd0, VEC[i].addr);
            wr(3'd1, VEC[i].txd);
            wr(3'd2, VEC[i].cmd);
            if (VEC[i].exp_req) begin
                check("R2 req_valid", {31'd0, req_valid}, 32'h1);
                check("R2 req_code", {28'd0, req_code}, {28'd0, VEC[i].cmd[3:0]});
                check("R2 req_addr", req_addr, VEC[i].addr);
                check("R3 req_data", req_data, VEC[i].exp_data);
                take_and_respond(VEC[i].rerr, VEC[i].rdat);
            end else begin
                check("R4/R5/R6 no request", {31'd0, req_valid}, 32'h0);
            end
            rd(3'd3, v); check("R8 status", v, {30'd0, VEC[i].exp_st});
            if (VEC[i].cmd[3:0] == 4'h8) begin
                rd(3'd4, v); check("R9 rxdata", v, VEC[i].rdat);
            end
            wr(3'd3, 32'h3);
        end

        // R9 rx unchanged by later non-read and error responses
        rd(3'd4, v); check("R9 rxdata held", v, 32'hCAFE_0123);

        // R7 hold while not ready
        wr(3'd0, 32'h0000_2000);
        wr(3'd1, 32'h0000_0077);
        wr(3'd2, 32'hA55A_000E);
        repeat (3) @(negedge clk);
        check("R7 valid held", {31'd0, req_valid}, 32'h1);
        check("R7 addr held", req_addr, 32'h0000_2000);
        check("R7 code held", {28'd0, req_code}, 32'hE);

        // R11 command while outstanding
        wr(3'd0, 32'h0000_3000);
        wr(3'd2, 32'hA55A_0009);
        check("R11 addr untouched", req_addr, 32'h0000_2000);
        check("R11 code untouched", {28'd0, req_code}, 32'hE);
        check("R11 data untouched", req_data, 32'h0);
        rd(3'd3, v); check("R11 error flag", v, 32'h2);
        take_and_respond(1'b0, 32'h0);
        rd(3'd3, v); check("R8 both sticky", v, 32'h3);

        // R10 write-one-to-clear
        wr(3'd3, 32'h0);
        rd(3'd3, v); check("R10 zero write", v, 32'h3);
        wr(3'd3, 32'h1);
        rd(3'd3, v); check("R10 clear done", v, 32'h2);
        wr(3'd3, 32'h2);
        rd(3'd3, v); check("R10 clear error", v, 32'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule